// File: doc/BRIEF.md
# Shared Interrupt Flag Bank

This block keeps a small bank of single-bit event flags that several sequencer engines and a host processor share. Each engine can issue one flag command per cycle: raise a flag, drop a flag, or raise a flag and then hold itself stalled until some other party drops that flag again. Each engine can also watch one flag for a chosen level, for example while it waits on a condition.

The host sees the whole bank. It can raise flags through a set mask and drop them through a write-one-to-clear mask. The low flags feed the host interrupt lines through an enable mask. When several parties raise and drop the same flag in one cycle, a raise always wins. Every result is registered and appears on the cycle after the request.

Top module: `flag_irq_unit`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `flags`, `sm_stall`, `sm_wait_met` and `cpu_irq` are all zero.
- R2: An engine command with op code 2'b01 (raise) for flag index k makes `flags[k]` read 1 on the next cycle.
- R3: An engine command with op code 2'b10 (drop) for flag index k makes `flags[k]` read 0 on the next cycle, unless another party raises k in the same cycle. Op code 2'b00 does nothing.
- R4: When a raise and a drop of the same flag come from any mix of engines and host in one cycle, the flag reads 1 on the next cycle.
- R5: With `cpu_clr_we` high, every 1 bit in `cpu_clr_mask` drops the flag at the same position on the next cycle. Flags at 0 bits of the mask keep their value.
- R6: With `cpu_set_we` high, every 1 bit in `cpu_set_mask` raises the flag at the same position on the next cycle.
- R7: Op code 2'b11 (raise-and-wait) for flag k raises `flags[k]` and sets the issuing engine's `sm_stall` bit on the next cycle. The stall stays high for as long as flag k reads 1.
- R8: A stalled engine's `sm_stall` bit falls in the same cycle in which its watched flag first reads 0.
- R9: A command from an engine whose `sm_stall` bit is high has no effect on any flag or on that engine's wait state.
- R10: `sm_wait_met[s]` on the cycle after a request equals `sm_poll_en[s]` AND (`flags` bit `sm_poll_idx` of that next cycle equals `sm_poll_level[s]`).
- R11: `cpu_irq[i]`, for the lowest `NUM_CPU_IRQ` flags, equals `flags[i]` AND the `cpu_irq_en[i]` value sampled one cycle earlier.
- R12: Commands from different engines to different flags in the same cycle all take effect together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sm_op | input | NUM_SM*2 | Per-engine command op code, engine s at bits [2s+1:2s] |
| sm_idx | input | NUM_SM*IDX_W | Per-engine command flag index |
| sm_poll_en | input | NUM_SM | Per-engine level watch enable |
| sm_poll_idx | input | NUM_SM*IDX_W | Per-engine watched flag index |
| sm_poll_level | input | NUM_SM | Per-engine level to watch for |
| cpu_set_we | input | 1 | Host set strobe |
| cpu_set_mask | input | NUM_FLAGS | Host set mask |
| cpu_clr_we | input | 1 | Host write-one-to-clear strobe |
| cpu_clr_mask | input | NUM_FLAGS | Host clear mask |
| cpu_irq_en | input | NUM_CPU_IRQ | Host interrupt enable per low flag |
| flags | output | NUM_FLAGS | Current flag values |
| sm_stall | output | NUM_SM | Per-engine stall from raise-and-wait |
| sm_wait_met | output | NUM_SM | Per-engine level watch result |
| cpu_irq | output | NUM_CPU_IRQ | Host interrupt lines |

## Verification
Every output is one register past its inputs. A command, host mask, enable or watch request applied in cycle T shows in `flags`, `cpu_irq` and `sm_wait_met` during T+1. A stall begins in T+1 after a raise-and-wait and ends in the cycle after the clearing request, which is the cycle the flag first reads 0. The bench applies inputs just after each rising edge. It advances a behavioural model of the bank once per edge from those inputs and compares all four outputs one time unit after the next edge, so each result is checked in exactly the cycle it is due.

// File: rtl/flag_irq_pkg.sv
package flag_irq_pkg;
  typedef enum logic [1:0] {
    OP_NONE     = 2'b00,
    OP_RAISE    = 2'b01,
    OP_DROP     = 2'b10,
    OP_RAISE_WT = 2'b11
  } flag_op_e;
endpackage

// File: rtl/flag_req_decode.sv
// Turns per-engine commands into raise/drop vectors; commands of stalled engines are masked.
module flag_req_decode
  import flag_irq_pkg::*;
#(
  parameter int NUM_SM    = 4,
  parameter int NUM_FLAGS = 8,
  parameter int IDX_W     = $clog2(NUM_FLAGS)
) (
  input  logic [NUM_SM*2-1:0]     sm_op,
  input  logic [NUM_SM*IDX_W-1:0] sm_idx,
  input  logic [NUM_SM-1:0]       sm_stall,
  output logic [NUM_FLAGS-1:0]    raise_vec,
  output logic [NUM_FLAGS-1:0]    drop_vec,
  output logic [NUM_SM-1:0]       wait_go
);
  logic [NUM_SM-1:0][NUM_FLAGS-1:0] raise_one;
  logic [NUM_SM-1:0][NUM_FLAGS-1:0] drop_one;

  for (genvar s = 0; s < NUM_SM; s++) begin : g_sm
    flag_op_e             op;
    logic [IDX_W-1:0]     idx;
    logic [NUM_FLAGS-1:0] hot;
    logic [NUM_FLAGS-1:0] r_loc;
    logic [NUM_FLAGS-1:0] d_loc;
    logic                 w_loc;

    assign op  = flag_op_e'(sm_op[s*2 +: 2]);
    assign idx = sm_idx[s*IDX_W +: IDX_W];

    always_comb begin
      hot = '0;
      hot[idx] = 1'b1;
    end

    always_comb begin
      r_loc = '0;
      d_loc = '0;
      w_loc = 1'b0;
      if (!sm_stall[s]) begin
        unique case (op)
          OP_RAISE:    r_loc = hot;
          OP_DROP:     d_loc = hot;
          OP_RAISE_WT: begin
            r_loc = hot;
            w_loc = 1'b1;
          end
          default:     ;
        endcase
      end
    end

    assign raise_one[s] = r_loc;
    assign drop_one[s]  = d_loc;
    assign wait_go[s]   = w_loc;
  end

  always_comb begin
    raise_vec = '0;
    drop_vec  = '0;
    for (int s = 0; s < NUM_SM; s++) begin
      raise_vec = raise_vec | raise_one[s];
      drop_vec  = drop_vec  | drop_one[s];
    end
  end
endmodule

// File: rtl/flag_bank.sv
// Flag storage: raise beats drop, host and engines merged.
module flag_bank #(
  parameter int NUM_FLAGS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_FLAGS-1:0] sm_raise,
  input  logic [NUM_FLAGS-1:0] sm_drop,
  input  logic                 cpu_set_we,
  input  logic [NUM_FLAGS-1:0] cpu_set_mask,
  input  logic                 cpu_clr_we,
  input  logic [NUM_FLAGS-1:0] cpu_clr_mask,
  output logic [NUM_FLAGS-1:0] flags_q,
  output logic [NUM_FLAGS-1:0] flags_nxt
);
  logic [NUM_FLAGS-1:0] all_raise;
  logic [NUM_FLAGS-1:0] all_drop;

  always_comb begin
    all_raise = sm_raise | (cpu_set_we ? cpu_set_mask : '0);
    all_drop  = sm_drop  | (cpu_clr_we ? cpu_clr_mask : '0);
    for (int i = 0; i < NUM_FLAGS; i++) begin
      if (all_raise[i])     flags_nxt[i] = 1'b1;
      else if (all_drop[i]) flags_nxt[i] = 1'b0;
      else                  flags_nxt[i] = flags_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) flags_q <= '0;
    else     flags_q <= flags_nxt;
  end
endmodule

// File: rtl/flag_waiter.sv
// One engine's raise-and-wait tracker and level watcher.
module flag_waiter #(
  parameter int NUM_FLAGS = 8,
  parameter int IDX_W     = $clog2(NUM_FLAGS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wait_go,
  input  logic [IDX_W-1:0]     wait_idx,
  input  logic [NUM_FLAGS-1:0] flags_nxt,
  input  logic                 poll_en,
  input  logic [IDX_W-1:0]     poll_idx,
  input  logic                 poll_level,
  output logic                 stall_q,
  output logic                 met_q
);
  logic [IDX_W-1:0] held_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      stall_q  <= 1'b0;
      held_idx <= '0;
      met_q    <= 1'b0;
    end else begin
      if (stall_q) begin
        if (!flags_nxt[held_idx]) stall_q <= 1'b0;
      end else if (wait_go) begin
        stall_q  <= 1'b1;
        held_idx <= wait_idx;
      end
      met_q <= poll_en && (flags_nxt[poll_idx] == poll_level);
    end
  end
endmodule

// File: rtl/flag_irq_unit.sv
module flag_irq_unit #(
  parameter int NUM_SM      = 4,
  parameter int NUM_FLAGS   = 8,
  parameter int NUM_CPU_IRQ = 4,
  parameter int IDX_W       = $clog2(NUM_FLAGS)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_SM*2-1:0]      sm_op,
  input  logic [NUM_SM*IDX_W-1:0]  sm_idx,
  input  logic [NUM_SM-1:0]        sm_poll_en,
  input  logic [NUM_SM*IDX_W-1:0]  sm_poll_idx,
  input  logic [NUM_SM-1:0]        sm_poll_level,
  input  logic                     cpu_set_we,
  input  logic [NUM_FLAGS-1:0]     cpu_set_mask,
  input  logic                     cpu_clr_we,
  input  logic [NUM_FLAGS-1:0]     cpu_clr_mask,
  input  logic [NUM_CPU_IRQ-1:0]   cpu_irq_en,
  output logic [NUM_FLAGS-1:0]     flags,
  output logic [NUM_SM-1:0]        sm_stall,
  output logic [NUM_SM-1:0]        sm_wait_met,
  output logic [NUM_CPU_IRQ-1:0]   cpu_irq
);
  logic [NUM_FLAGS-1:0] raise_vec;
  logic [NUM_FLAGS-1:0] drop_vec;
  logic [NUM_SM-1:0]    wait_go;
  logic [NUM_FLAGS-1:0] flags_nxt;
  logic [NUM_CPU_IRQ-1:0] irq_q;

  flag_req_decode #(
    .NUM_SM(NUM_SM), .NUM_FLAGS(NUM_FLAGS), .IDX_W(IDX_W)
  ) u_decode (
    .sm_op(sm_op), .sm_idx(sm_idx), .sm_stall(sm_stall),
    .raise_vec(raise_vec), .drop_vec(drop_vec), .wait_go(wait_go)
  );

  flag_bank #(.NUM_FLAGS(NUM_FLAGS)) u_bank (
    .clk(clk), .rst(rst),
    .sm_raise(raise_vec), .sm_drop(drop_vec),
    .cpu_set_we(cpu_set_we), .cpu_set_mask(cpu_set_mask),
    .cpu_clr_we(cpu_clr_we), .cpu_clr_mask(cpu_clr_mask),
    .flags_q(flags), .flags_nxt(flags_nxt)
  );

  for (genvar s = 0; s < NUM_SM; s++) begin : g_wait
    flag_waiter #(.NUM_FLAGS(NUM_FLAGS), .IDX_W(IDX_W)) u_waiter (
      .clk(clk), .rst(rst),
      .wait_go(wait_go[s]),
      .wait_idx(sm_idx[s*IDX_W +: IDX_W]),
      .flags_nxt(flags_nxt),
      .poll_en(sm_poll_en[s]),
      .poll_idx(sm_poll_idx[s*IDX_W +: IDX_W]),
      .poll_level(sm_poll_level[s]),
      .stall_q(sm_stall[s]),
      .met_q(sm_wait_met[s])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= '0;
    else     irq_q <= flags_nxt[NUM_CPU_IRQ-1:0] & cpu_irq_en;
  end

  assign cpu_irq = irq_q;
endmodule

// File: rtl/flag_irq_checker.sv
module flag_irq_checker #(
  parameter int NUM_SM      = 4,
  parameter int NUM_FLAGS   = 8,
  parameter int NUM_CPU_IRQ = 4,
  parameter int IDX_W       = $clog2(NUM_FLAGS)
) (
  input logic                    clk,
  input logic                    rst,
  input logic [NUM_SM*2-1:0]     sm_op,
  input logic [NUM_SM*IDX_W-1:0] sm_idx,
  input logic [NUM_SM-1:0]       sm_poll_en,
  input logic                    cpu_set_we,
  input logic [NUM_FLAGS-1:0]    cpu_set_mask,
  input logic                    cpu_clr_we,
  input logic [NUM_FLAGS-1:0]    cpu_clr_mask,
  input logic [NUM_FLAGS-1:0]    flags,
  input logic [NUM_SM-1:0]       sm_stall,
  input logic [NUM_SM-1:0]       sm_wait_met,
  input logic [NUM_CPU_IRQ-1:0]  cpu_irq
);
  logic [NUM_FLAGS-1:0] any_raise;

  always_comb begin
    any_raise = cpu_set_we ? cpu_set_mask : '0;
    for (int s = 0; s < NUM_SM; s++) begin
      if (!sm_stall[s] && sm_op[s*2])
        any_raise[sm_idx[s*IDX_W +: IDX_W]] = 1'b1;
    end
  end

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    p_cpu_set_r6: assert property (@(posedge clk) disable iff (rst)
      (cpu_set_we && cpu_set_mask[i]) |=> flags[i]);
    p_cpu_clr_r5: assert property (@(posedge clk) disable iff (rst)
      (cpu_clr_we && cpu_clr_mask[i] && !any_raise[i]) |=> !flags[i]);
  end

  for (genvar s = 0; s < NUM_SM; s++) begin : g_eng
    p_stall_flag_r7: assert property (@(posedge clk) disable iff (rst)
      sm_stall[s] |-> (|flags));
    p_stall_cause_r7: assert property (@(posedge clk) disable iff (rst)
      $rose(sm_stall[s]) |-> ($past(sm_op[s*2 +: 2]) == 2'b11));
    p_met_off_r10: assert property (@(posedge clk) disable iff (rst)
      !$past(sm_poll_en[s]) |-> !sm_wait_met[s]);
  end

  for (genvar i = 0; i < NUM_CPU_IRQ; i++) begin : g_irq
    p_irq_src_r11: assert property (@(posedge clk) disable iff (rst)
      cpu_irq[i] |-> flags[i]);
  end
endmodule

bind flag_irq_unit flag_irq_checker #(
  .NUM_SM(NUM_SM), .NUM_FLAGS(NUM_FLAGS), .NUM_CPU_IRQ(NUM_CPU_IRQ), .IDX_W(IDX_W)
) u_checker (
  .clk(clk), .rst(rst), .sm_op(sm_op), .sm_idx(sm_idx), .sm_poll_en(sm_poll_en),
  .cpu_set_we(cpu_set_we), .cpu_set_mask(cpu_set_mask),
  .cpu_clr_we(cpu_clr_we), .cpu_clr_mask(cpu_clr_mask),
  .flags(flags), .sm_stall(sm_stall), .sm_wait_met(sm_wait_met), .cpu_irq(cpu_irq)
);

// File: tb/flag_irq_unit_tb.sv
module flag_irq_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NSM = 4;
  localparam int NF  = 8;
  localparam int NIRQ = 4;
  localparam int IW  = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NSM*2-1:0]  sm_op = '0;
  logic [NSM*IW-1:0] sm_idx = '0;
  logic [NSM-1:0]    sm_poll_en = '0;
  logic [NSM*IW-1:0] sm_poll_idx = '0;
  logic [NSM-1:0]    sm_poll_level = '0;
  logic              cpu_set_we = 1'b0;
  logic [NF-1:0]     cpu_set_mask = '0;
  logic              cpu_clr_we = 1'b0;
  logic [NF-1:0]     cpu_clr_mask = '0;
  logic [NIRQ-1:0]   cpu_irq_en = '0;
  logic [NF-1:0]     flags;
  logic [NSM-1:0]    sm_stall;
  logic [NSM-1:0]    sm_wait_met;
  logic [NIRQ-1:0]   cpu_irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  flag_irq_unit u_dut (
    .clk(clk), .rst(rst), .sm_op(sm_op), .sm_idx(sm_idx),
    .sm_poll_en(sm_poll_en), .sm_poll_idx(sm_poll_idx), .sm_poll_level(sm_poll_level),
    .cpu_set_we(cpu_set_we), .cpu_set_mask(cpu_set_mask),
    .cpu_clr_we(cpu_clr_we), .cpu_clr_mask(cpu_clr_mask),
    .cpu_irq_en(cpu_irq_en), .flags(flags), .sm_stall(sm_stall),
    .sm_wait_met(sm_wait_met), .cpu_irq(cpu_irq)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  string tag = "R1";

  // behavioural model state
  bit [NF-1:0]   m_flags = '0;
  bit [NSM-1:0]  m_stall = '0;
  int            m_widx [NSM];
  bit [NSM-1:0]  m_met = '0;
  bit [NIRQ-1:0] m_irq = '0;

  task automatic check(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic void model_step();
    bit [NF-1:0] up;
    bit [NF-1:0] dn;
    bit [NF-1:0] nf;
    up = cpu_set_we ? cpu_set_mask : '0;
    dn = cpu_clr_we ? cpu_clr_mask : '0;
    for (int s = 0; s < NSM; s++) begin
      int op;
      int ix;
      op = sm_op[s*2 +: 2];
      ix = sm_idx[s*IW +: IW];
      if (!m_stall[s]) begin
        if (op == 1 || op == 3) up[ix] = 1'b1;
        if (op == 2) dn[ix] = 1'b1;
      end
    end
    for (int i = 0; i < NF; i++) begin
      if (up[i]) nf[i] = 1'b1;
      else if (dn[i]) nf[i] = 1'b0;
      else nf[i] = m_flags[i];
    end
    for (int s = 0; s < NSM; s++) begin
      if (m_stall[s]) begin
        if (nf[m_widx[s]] == 1'b0) m_stall[s] = 1'b0;
      end else if (sm_op[s*2 +: 2] == 2'b11) begin
        m_stall[s] = 1'b1;
        m_widx[s] = sm_idx[s*IW +: IW];
      end
      m_met[s] = sm_poll_en[s] && (nf[sm_poll_idx[s*IW +: IW]] == sm_poll_level[s]);
    end
    m_irq = nf[NIRQ-1:0] & cpu_irq_en;
    m_flags = nf;
  endfunction

  task automatic compare_all();
    check("flags", flags, m_flags);
    check("sm_stall", sm_stall, m_stall);
    check("sm_wait_met", sm_wait_met, m_met);
    check("cpu_irq", cpu_irq, m_irq);
  endtask

  task automatic step();
    model_step();
    @(posedge clk);
    #1;
    compare_all();
  endtask

  task automatic idle_inputs();
    sm_op = '0;
    cpu_set_we = 1'b0;
    cpu_clr_we = 1'b0;
    cpu_set_mask = '0;
    cpu_clr_mask = '0;
  endtask

  task automatic cmd(int s, int op, int ix);
    sm_op[s*2 +: 2] = op[1:0];
    sm_idx[s*IW +: IW] = ix[IW-1:0];
  endtask

  initial begin
    #(CLK_PERIOD*100000);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < NSM; s++) m_widx[s] = 0;
    // R1: reset state
    tag = "R1";
    repeat (3) @(posedge clk);
    #1;
    compare_all();
    rst = 1'b0;
    step();

    // R2: single raise
    tag = "R2";
    cmd(0, 1, 5); step(); idle_inputs();
    check("R2 flag5", flags[5], 1);
    step();

    // R3: single drop, and no-op code
    tag = "R3";
    cmd(1, 2, 5); step(); idle_inputs();
    check("R3 flag5", flags[5], 0);
    cmd(2, 0, 6); step(); idle_inputs();

    // R12: several engines at once
    tag = "R12";
    cmd(0, 1, 1); cmd(1, 1, 2); cmd(2, 1, 6); cmd(3, 1, 7); step(); idle_inputs();
    check("R12 flags", flags, 8'hC6);

    // R4: raise beats drop
    tag = "R4";
    cmd(0, 1, 3); cmd(1, 2, 3); step(); idle_inputs();
    check("R4 sm vs sm", flags[3], 1);
    cpu_clr_we = 1'b1; cpu_clr_mask = 8'h04; cmd(2, 1, 2); step(); idle_inputs();
    check("R4 cpu clr vs sm", flags[2], 1);
    cpu_set_we = 1'b1; cpu_set_mask = 8'h02; cmd(3, 2, 1); step(); idle_inputs();
    check("R4 sm clr vs cpu", flags[1], 1);

    // R5: write-one-to-clear
    tag = "R5";
    cpu_clr_we = 1'b1; cpu_clr_mask = 8'h84; step(); idle_inputs();
    check("R5 flags", flags, 8'h4A);
    cpu_clr_mask = 8'hFF; step(); idle_inputs();
    check("R5 no strobe", flags, 8'h4A);

    // R6 and R11: host set and interrupt enables
    tag = "R6";
    cpu_set_we = 1'b1; cpu_set_mask = 8'h01; cpu_irq_en = 4'b1001; step(); idle_inputs();
    check("R6 flag0", flags[0], 1);
    tag = "R11";
    check("R11 irq", cpu_irq, 4'b1001);
    cpu_irq_en = 4'b0001; step();
    check("R11 irq masked", cpu_irq, 4'b0001);
    cpu_irq_en = 4'b0000; step();
    check("R11 irq off", cpu_irq, 4'b0000);

    // R7: raise-and-wait
    tag = "R7";
    cmd(2, 3, 4); step(); idle_inputs();
    check("R7 stall", sm_stall[2], 1);
    check("R7 flag4", flags[4], 1);
    repeat (4) step();
    check("R7 stall held", sm_stall[2], 1);

    // R9: stalled engine commands ignored
    tag = "R9";
    cmd(2, 2, 4); step(); idle_inputs();
    check("R9 flag4 kept", flags[4], 1);
    cmd(2, 1, 5); step(); idle_inputs();
    check("R9 flag5 not raised", flags[5], 0);
    cmd(2, 3, 6); step(); idle_inputs();

    // R8: release on the cycle the flag reads 0
    tag = "R8";
    cpu_clr_we = 1'b1; cpu_clr_mask = 8'h10; step(); idle_inputs();
    check("R8 released", sm_stall[2], 0);
    check("R8 flag4", flags[4], 0);
    tag = "R4";
    cmd(3, 3, 7); cmd(0, 2, 7); step(); idle_inputs();
    check("R4 wait vs drop", sm_stall[3], 1);
    tag = "R8";
    cmd(0, 2, 7); step(); idle_inputs();
    check("R8 released by engine", sm_stall[3], 0);

    // R10: level watch
    tag = "R10";
    sm_poll_en = 4'b0010; sm_poll_idx = '0; sm_poll_idx[1*IW +: IW] = 3'd3;
    sm_poll_level = 4'b0010; step();
    check("R10 high met", sm_wait_met[1], 1);
    sm_poll_level = 4'b0000; step();
    check("R10 low unmet", sm_wait_met[1], 0);
    cmd(0, 2, 3); step(); idle_inputs();
    check("R10 low met after drop", sm_wait_met[1], 1);
    sm_poll_en = '0; step();
    check("R10 disabled", sm_wait_met[1], 0);

    // mixed traffic against the model (R2 R3 R4 R5 R6 R7 R8 R9 R10 R11 R12)
    tag = "R4 mixed";
    for (int n = 0; n < 400; n++) begin
      sm_op = NSM*2'($urandom);
      sm_idx = (NSM*IW)'($urandom);
      sm_poll_en = NSM'($urandom);
      sm_poll_idx = (NSM*IW)'($urandom);
      sm_poll_level = NSM'($urandom);
      cpu_set_we = ($urandom % 5) == 0;
      cpu_set_mask = NF'($urandom);
      cpu_clr_we = ($urandom % 3) == 0;
      cpu_clr_mask = NF'($urandom);
      cpu_irq_en = NIRQ'($urandom);
      step();
    end
    idle_inputs();
    cpu_clr_we = 1'b1; cpu_clr_mask = '1; step(); idle_inputs();
    step();

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule